// File: doc/BRIEF.md
# Processor Bus Address Decoder

This block turns the address, cycle-type and strobe lines of an 8-bit-data, 20-bit-address microprocessor bus into the select and command signals for the chips on that bus. It decodes a fixed map that mixes memory and I/O. A 32 KB boot ROM sits at the top of memory and is built from four 8 KB devices. A 512 KB SRAM bank fills the lower half of memory. A four-register parallel I/O peripheral sits at I/O ports 60H–63H. All chip selects and command strobes are active low.

The ROM devices are too slow for a zero-wait bus cycle. For that reason the block pulls READY low for one clock at the start of every ROM read, which gives the processor one wait state. SRAM and I/O cycles run with READY held high. All decode paths are combinational. Only the READY pulse is registered.

Top module: `bus_addr_decoder`

## Requirements
- R1: The command strobes follow the cycle type (`mem_io`: 1 = memory, 0 = I/O) and the active-low strobes. `mem_rd_n` is low only for a memory read, `mem_wr_n` only for a memory write, `io_rd_n` only for an I/O read and `io_wr_n` only for an I/O write.
- R2: While both `rd_n` and `wr_n` are high, every chip select and every command strobe is high, whatever the address.
- R3: A memory read in F8000H–FFFFFH drives exactly one ROM select low. That select is `rom_cs_n[k]`, where k = addr[14:13], so F8000H selects bit 0 and FE000H–FFFFFH (including FFFF0H) selects bit 3.
- R4: A memory write anywhere in F8000H–FFFFFH leaves all four ROM selects high.
- R5: A memory read or write with addr[19] = 0 (00000H–7FFFFH) drives `sram_cs_n` low.
- R6: A memory cycle in 80000H–F7FFFH drives no chip select low.
- R7: An I/O read or write with addr[15:2] = 0018H (ports 0060H–0063H) drives `ppi_cs_n` low. addr[19:16] are ignored for this decode, and other ports leave it high. `ppi_reg` always equals addr[1:0].
- R8: READY goes low in the clock after the first clock edge that samples a ROM read. It stays low for exactly one clock, even if the read is held longer.
- R9: READY stays high through SRAM, I/O and idle cycles, and through ROM writes.
- R10: While `rst_n` is low at a clock edge, READY is high after that edge, and a ROM read sampled during reset produces no pulse.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 20 | Address bus; I/O cycles use bits 15:0 |
| mem_io | input | 1 | Cycle type: 1 memory, 0 I/O |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rom_cs_n | output | 4 | One select per 8 KB ROM device, active low |
| sram_cs_n | output | 1 | SRAM bank select, active low |
| ppi_cs_n | output | 1 | Parallel peripheral select, active low |
| ppi_reg | output | 2 | Register index inside the peripheral |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| io_rd_n | output | 1 | I/O read command, active low |
| io_wr_n | output | 1 | I/O write command, active low |
| ready | output | 1 | Wait-state request; low holds the processor |

## Verification
Selects, command strobes and `ppi_reg` are combinational, so they are due in the same cycle as the inputs that cause them. READY is due one clock edge after the ROM read is first sampled and returns high at the following edge. The bench drives each cycle's inputs at the falling edge. It queues the expected output word, and for READY it uses a small model of the registered pulse based on the inputs and reset seen at the previous rising edge. The monitor compares a few nanoseconds after that same falling edge, so every combinational result is checked in its own cycle and every READY value one edge after its cause.

// File: rtl/bus_dec_pkg.sv
// Shared constants and types for the bus address decoder.
// Assumes a bus with 20 address bits and 16-bit I/O port numbers.
package bus_dec_pkg;

    // Cycle type carried on the memory/IO qualifier line
    typedef enum logic {
        CYC_IO  = 1'b0,
        CYC_MEM = 1'b1
    } cyc_e;

    // Internal active-high command set, inverted at the block edge
    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
    } cmd_t;

endpackage

// File: rtl/line_dec.sv
// Generic N-to-2^N line decoder with three enables (one high, two low).
// Assumes nothing about the select value; every output is active low and
// an output drives low only when all three enables are true.
module line_dec #(
    parameter int SEL_W = 3
) (
    input  logic                  en_hi,
    input  logic                  en_lo_a_n,
    input  logic                  en_lo_b_n,
    input  logic [SEL_W-1:0]      sel,
    output logic [(1<<SEL_W)-1:0] out_n
);
    localparam int OUTS = 1 << SEL_W;

    logic enabled;

    // Combine the three enable conditions
    assign enabled = en_hi && !en_lo_a_n && !en_lo_b_n;

    // One output per select value
    for (genvar i = 0; i < OUTS; i++) begin : g_out
        assign out_n[i] = !(enabled && (sel == SEL_W'(i)));
    end
endmodule

// File: rtl/region_dec.sv
// Region decode for the fixed memory/I-O map.
// Assumes ROM devices fill the upper half of one decoder-sized block at the
// very top of memory, SRAM fills the lower half of memory, and the
// peripheral occupies 2^PPI_REG_W consecutive ports starting at PPI_BASE.
module region_dec #(
    parameter int                ADDR_W    = 20,
    parameter int                IO_W      = 16,
    parameter int                DEV_AW    = 13,
    parameter int                ROM_DEV_W = 2,
    parameter int                PPI_REG_W = 2,
    parameter logic [IO_W-1:0]   PPI_BASE  = 16'h0060
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    mem_cyc,
    input  logic                    rd,
    input  logic                    wr,
    output logic [(1<<ROM_DEV_W)-1:0] rom_cs_n,
    output logic                    sram_sel,
    output logic                    ppi_sel
);
    localparam int DEC_W   = ROM_DEV_W + 1;
    localparam int DEC_LO  = DEV_AW;
    localparam int DEC_HI  = DEV_AW + DEC_W - 1;
    localparam int TOP_LO  = DEC_HI + 1;
    localparam int TOP_W   = ADDR_W - TOP_LO;
    localparam int ROM_N   = 1 << ROM_DEV_W;
    localparam int DEC_N   = 1 << DEC_W;

    logic             top_ones;
    logic [DEC_N-1:0] dec_n;

    // Address bits above the decoder must all be one for the ROM block
    assign top_ones = (addr[ADDR_W-1:TOP_LO] == {TOP_W{1'b1}});

    // Decoder enabled only on memory reads into the top block
    line_dec #(.SEL_W(DEC_W)) u_rom_dec (
        .en_hi    (top_ones),
        .en_lo_a_n(!mem_cyc),
        .en_lo_b_n(!rd),
        .sel      (addr[DEC_HI:DEC_LO]),
        .out_n    (dec_n)
    );

    // ROM devices take the upper half of the decoder outputs
    for (genvar k = 0; k < ROM_N; k++) begin : g_rom
        assign rom_cs_n[k] = dec_n[ROM_N + k];
    end

    // SRAM covers the lower half of memory for either strobe
    assign sram_sel = mem_cyc && (rd || wr) && !addr[ADDR_W-1];

    // Peripheral decode compares every I/O port bit above the register index
    assign ppi_sel = !mem_cyc && (rd || wr) &&
                     (addr[IO_W-1:PPI_REG_W] == PPI_BASE[IO_W-1:PPI_REG_W]);
endmodule

// File: rtl/wait_gen.sv
// Wait-state generator: one-clock READY low pulse at the start of a ROM read.
// Assumes the ROM read condition is stable from one clock edge to the next
// and that back-to-back ROM reads are separated by a cycle without it.
module wait_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic rom_rd,
    output logic ready
);
    logic rom_rd_q;

    // Remember last sampled ROM read and register the READY pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_rd_q <= 1'b0;
            ready    <= 1'b1;
        end else begin
            rom_rd_q <= rom_rd;
            ready    <= !(rom_rd && !rom_rd_q);
        end
    end
endmodule

// File: rtl/bus_addr_decoder.sv
// Top of the processor bus address decoder.
// Produces active-low chip selects, active-low command strobes and a
// wait-state READY for a fixed map: ROM at the top of memory, SRAM in the
// lower half, a parallel peripheral in I/O space. Assumes rd_n and wr_n are
// never low together.
module bus_addr_decoder
    import bus_dec_pkg::*;
#(
    parameter int              ADDR_W    = 20,
    parameter int              IO_W      = 16,
    parameter int              DEV_AW    = 13,
    parameter int              ROM_DEV_W = 2,
    parameter int              PPI_REG_W = 2,
    parameter logic [IO_W-1:0] PPI_BASE  = 16'h0060
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      mem_io,
    input  logic                      rd_n,
    input  logic                      wr_n,
    output logic [(1<<ROM_DEV_W)-1:0] rom_cs_n,
    output logic                      sram_cs_n,
    output logic                      ppi_cs_n,
    output logic [PPI_REG_W-1:0]      ppi_reg,
    output logic                      mem_rd_n,
    output logic                      mem_wr_n,
    output logic                      io_rd_n,
    output logic                      io_wr_n,
    output logic                      ready
);
    localparam int ROM_N = 1 << ROM_DEV_W;

    logic             mem_cyc;
    logic             rd;
    logic             wr;
    cmd_t             cmd;
    logic             sram_sel;
    logic             ppi_sel;
    logic             rom_rd;

    // Normalise the control lines to active high
    assign mem_cyc = (cyc_e'(mem_io) == CYC_MEM);
    assign rd      = !rd_n;
    assign wr      = !wr_n;

    // Build the four commands from cycle type and strobe
    always_comb begin
        cmd.mem_rd = mem_cyc  && rd;
        cmd.mem_wr = mem_cyc  && wr;
        cmd.io_rd  = !mem_cyc && rd;
        cmd.io_wr  = !mem_cyc && wr;
    end

    // Drive commands out active low
    assign mem_rd_n = !cmd.mem_rd;
    assign mem_wr_n = !cmd.mem_wr;
    assign io_rd_n  = !cmd.io_rd;
    assign io_wr_n  = !cmd.io_wr;

    region_dec #(
        .ADDR_W   (ADDR_W),
        .IO_W     (IO_W),
        .DEV_AW   (DEV_AW),
        .ROM_DEV_W(ROM_DEV_W),
        .PPI_REG_W(PPI_REG_W),
        .PPI_BASE (PPI_BASE)
    ) u_region (
        .addr    (addr),
        .mem_cyc (mem_cyc),
        .rd      (rd),
        .wr      (wr),
        .rom_cs_n(rom_cs_n),
        .sram_sel(sram_sel),
        .ppi_sel (ppi_sel)
    );

    // Select outputs and register index
    assign sram_cs_n = !sram_sel;
    assign ppi_cs_n  = !ppi_sel;
    assign ppi_reg   = addr[PPI_REG_W-1:0];

    // Any ROM select low marks a ROM read
    assign rom_rd = (rom_cs_n != {ROM_N{1'b1}});

    wait_gen u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .rom_rd(rom_rd),
        .ready (ready)
    );
endmodule

// File: rtl/bus_addr_decoder_chk.sv
// Assertion checker for bus_addr_decoder, attached by bind.
// Assumes default parameters (20-bit address, four ROM devices).
module bus_addr_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [19:0] addr,
    input logic        mem_io,
    input logic        rd_n,
    input logic        wr_n,
    input logic [3:0]  rom_cs_n,
    input logic        sram_cs_n,
    input logic        ppi_cs_n,
    input logic        mem_rd_n,
    input logic        mem_wr_n,
    input logic        io_rd_n,
    input logic        io_wr_n,
    input logic        ready
);
    logic rom_read;
    logic rom_read_q;

    // Independent view of a ROM read from the ports
    assign rom_read = mem_io && !rd_n && (addr[19:15] == 5'h1F);

    // Track the previously sampled ROM read
    always_ff @(posedge clk) begin
        if (!rst_n) rom_read_q <= 1'b0;
        else        rom_read_q <= rom_read;
    end

    a_r1_mem_rd_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> (mem_io && !rd_n));
    a_r1_io_wr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr_n |-> (!mem_io && !wr_n));
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n && wr_n) |-> (&rom_cs_n && sram_cs_n && ppi_cs_n &&
                            mem_rd_n && mem_wr_n && io_rd_n && io_wr_n));
    a_r3_rom_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~rom_cs_n));
    a_r4_rom_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_cs_n != 4'hF) |-> (!rd_n && mem_io && addr[19:15] == 5'h1F));
    a_r5_sram_low_half: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_cs_n |-> (!addr[19] && mem_io));
    a_r7_ppi_io_only: assert property (@(posedge clk) disable iff (!rst_n)
        !ppi_cs_n |-> (!mem_io && addr[15:2] == 14'h0018));
    a_r8_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_read && !rom_read_q) |=> !ready);
    a_r8_pulse_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ready);
    a_r9_ready_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> $past(rom_read));
endmodule

bind bus_addr_decoder bus_addr_decoder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .mem_io   (mem_io),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .rom_cs_n (rom_cs_n),
    .sram_cs_n(sram_cs_n),
    .ppi_cs_n (ppi_cs_n),
    .mem_rd_n (mem_rd_n),
    .mem_wr_n (mem_wr_n),
    .io_rd_n  (io_rd_n),
    .io_wr_n  (io_wr_n),
    .ready    (ready)
);

// File: tb/bus_addr_decoder_tb.sv
// Scoreboard bench for bus_addr_decoder: the driver queues expected output
// words, the monitor compares them shortly after each falling edge.
module bus_addr_decoder_tb;

    typedef struct {
        logic [12:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] addr = '0;
    logic        mem_io = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [3:0]  rom_cs_n;
    logic        sram_cs_n;
    logic        ppi_cs_n;
    logic [1:0]  ppi_reg;
    logic        mem_rd_n;
    logic        mem_wr_n;
    logic        io_rd_n;
    logic        io_wr_n;
    logic        ready;

    item_t q[$];
    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    // Model of the registered READY, advanced once per falling edge
    logic  m_ready = 1'b1;
    logic  m_q = 1'b0;
    logic  last_rr = 1'b0;
    logic  last_rst = 1'b0;

    always #5 clk = ~clk;

    bus_addr_decoder u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .mem_io   (mem_io),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .rom_cs_n (rom_cs_n),
        .sram_cs_n(sram_cs_n),
        .ppi_cs_n (ppi_cs_n),
        .ppi_reg  (ppi_reg),
        .mem_rd_n (mem_rd_n),
        .mem_wr_n (mem_wr_n),
        .io_rd_n  (io_rd_n),
        .io_wr_n  (io_wr_n),
        .ready    (ready)
    );

    // Expected combinational word from the requirements
    function automatic logic [11:0] model(input logic [19:0] a, input logic m,
                                          input logic r, input logic w);
        logic [3:0] rom;
        logic       sram;
        logic       ppi;
        rom  = (m && r && a[19:15] == 5'h1F) ? ~(4'b0001 << a[14:13]) : 4'hF;
        sram = m && (r || w) && !a[19];
        ppi  = !m && (r || w) && (a[15:2] == 14'h0018);
        return {rom, !sram, !ppi, a[1:0], !(m && r), !(m && w), !(!m && r), !(!m && w)};
    endfunction

    // Drive one bus cycle and queue its expected outputs
    task automatic apply(input logic [19:0] a, input logic m, input logic r,
                         input logic w, input string tag);
        @(negedge clk);
        if (!last_rst) begin
            m_ready = 1'b1;
            m_q     = 1'b0;
        end else begin
            m_ready = !(last_rr && !m_q);
            m_q     = last_rr;
        end
        addr   = a;
        mem_io = m;
        rd_n   = !r;
        wr_n   = !w;
        q.push_back('{exp: {model(a, m, r, w), m_ready}, tag: tag});
        last_rr  = m && r && (a[19:15] == 5'h1F);
        last_rst = rst_n;
    endtask

    // Monitor: compare queued expectations away from the clock edges
    always @(negedge clk) begin
        #2;
        while (q.size() > 0) begin
            item_t it;
            logic [12:0] act;
            it  = q.pop_front();
            act = {rom_cs_n, sram_cs_n, ppi_cs_n, ppi_reg,
                   mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, ready};
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Stimulus sequence
    initial begin
        // R10: reset state, ROM read during reset gives no pulse
        apply(20'h00000, 1'b1, 1'b0, 1'b0, "R10 reset idle");
        apply(20'hF8000, 1'b1, 1'b1, 1'b0, "R10 rom read in reset");
        apply(20'hF8000, 1'b1, 1'b1, 1'b0, "R10 rom read in reset");
        apply(20'h00000, 1'b1, 1'b0, 1'b0, "R10 reset idle");
        rst_n = 1'b1;
        apply(20'h00000, 1'b1, 1'b0, 1'b0, "R2 idle after reset");
        // R2: no strobe, addresses that would otherwise select
        apply(20'hFFFF0, 1'b1, 1'b0, 1'b0, "R2 idle rom addr");
        apply(20'h00061, 1'b0, 1'b0, 1'b0, "R2 idle ppi port");
        // R5 / R1: SRAM boundaries
        apply(20'h00000, 1'b1, 1'b1, 1'b0, "R5 sram low read");
        apply(20'h7FFFF, 1'b1, 1'b0, 1'b1, "R5 sram top write");
        apply(20'h7FFFF, 1'b1, 1'b1, 1'b0, "R9 ready after sram");
        // R6: unmapped hole boundaries
        apply(20'h80000, 1'b1, 1'b1, 1'b0, "R6 hole bottom read");
        apply(20'hF7FFF, 1'b1, 1'b1, 1'b0, "R6 hole top read");
        apply(20'hF0000, 1'b1, 1'b0, 1'b1, "R6 hole write");
        // R3 / R8: each ROM device, pulse then recovery
        apply(20'hF8000, 1'b1, 1'b1, 1'b0, "R3 rom dev0 bottom");
        apply(20'hF8000, 1'b1, 1'b1, 1'b0, "R8 ready low one clock");
        apply(20'hF8000, 1'b1, 1'b1, 1'b0, "R8 ready back high while held");
        apply(20'h00000, 1'b1, 1'b0, 1'b0, "R8 idle gap");
        apply(20'hF9FFF, 1'b1, 1'b1, 1'b0, "R3 rom dev0 top");
        apply(20'h00000, 1'b1, 1'b0, 1'b0, "R8 pulse after dev0 top");
        apply(20'hFA000, 1'b1, 1'b1, 1'b0, "R3 rom dev1");
        apply(20'hFC000, 1'b1, 1'b1, 1'b0, "R3 rom dev2 held read");
        apply(20'h00000, 1'b1, 1'b0, 1'b0, "R8 no second pulse");
        apply(20'hFFFF0, 1'b1, 1'b1, 1'b0, "R3 rom dev3 reset vector");
        apply(20'hFFFFF, 1'b1, 1'b1, 1'b0, "R3 rom dev3 top");
        apply(20'h00000, 1'b1, 1'b0, 1'b0, "R8 recovery");
        // R4: ROM writes select nothing and add no wait
        apply(20'hF8000, 1'b1, 1'b0, 1'b1, "R4 rom write bottom");
        apply(20'hFFFFF, 1'b1, 1'b0, 1'b1, "R4 rom write top");
        apply(20'h00000, 1'b1, 1'b0, 1'b0, "R9 no wait after rom write");
        // R7 / R1: peripheral ports and neighbours
        apply(20'h0005F, 1'b0, 1'b1, 1'b0, "R7 port below window");
        apply(20'h00060, 1'b0, 1'b1, 1'b0, "R7 port 60 read");
        apply(20'h00061, 1'b0, 1'b0, 1'b1, "R7 port 61 write");
        apply(20'h00062, 1'b0, 1'b1, 1'b0, "R7 port 62 read");
        apply(20'h00063, 1'b0, 1'b0, 1'b1, "R7 port 63 write");
        apply(20'h00064, 1'b0, 1'b1, 1'b0, "R7 port above window");
        apply(20'hF0060, 1'b0, 1'b1, 1'b0, "R7 upper bits ignored");
        apply(20'h01060, 1'b0, 1'b1, 1'b0, "R7 port bit 12 set");
        apply(20'hFFFF0, 1'b0, 1'b1, 1'b0, "R9 io read at rom address");
        apply(20'h00000, 1'b1, 1'b0, 1'b0, "R9 ready after io");
        apply(20'h00000, 1'b1, 1'b0, 1'b0, "R1 final idle");
        repeat (3) @(negedge clk);
        #4;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule